// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block is the supervisory state machine of a synchronous buck regulator controller. It reads already-digitised comparator flags from the analog front end:

- supply-good, with its hysteresis applied upstream;
- over-current, sensed while the low-side switch conducts;
- feedback under-voltage;
- feedback over-voltage;
- an active-low shutdown request.

From these it drives a 10-bit reference code for the error amplifier's DAC, a switching enable for the gate drivers, a latched-fault flag and a request that forces the low-side switch on.

After supply-good rises and shutdown is released, the sequencer starts switching with the reference code at zero. It then raises the code one step every `STEP_CYC` cycles until the code equals the regulation target, and holds it there.

It handles the fault inputs as follows:

- **Over-current:** each event stops switching for one cycle and restarts the soft-start. The event that brings the event count to `OC_LIMIT` latches the converter off instead.
- **Under-voltage:** during regulation it stops switching for `HICCUP_CYC` cycles and then retries, for as long as the condition lasts, and never latches. It is ignored during the ramp.
- **Over-voltage:** it only asserts the low-side request. It does not change the state.
- **Shutdown and supply loss:** each returns the block to idle, clears the over-current count and releases a latched fault.

Top module: `ssfault_seq`

## Requirements
- R1: While reset is active or `supply_ok` is low, `sw_en`, `fault_latched` and `force_low` are 0 and `ref_code` is 0.
- R2: In the cycle after an edge that samples `supply_ok`=1 and `shdn_n`=1 from idle, `sw_en` is 1 and `ref_code` is 0.
- R3: k cycles after soft-start entry, `ref_code` equals floor(k/STEP_CYC). It never exceeds REF_CODE, and while switching continues it never decreases and never rises by more than 1 per cycle.
- R4: Once the ramp has reached REF_CODE, `ref_code` holds REF_CODE and `sw_en` stays 1 while no fault is present.
- R5: An over-current flag sampled during the ramp or regulation clears `sw_en` and `ref_code` for exactly one cycle. A fresh soft-start from code 0 follows.
- R6: The over-current event that brings the count to OC_LIMIT (4 by default) sets `fault_latched`. While latched, `sw_en` and `force_low` are 0 whatever the over-current, under-voltage and over-voltage inputs do.
- R7: An under-voltage flag sampled during regulation clears `sw_en` for exactly HICCUP_CYC cycles. Soft-start then restarts from 0. This repeats without limit and never sets `fault_latched`.
- R8: The under-voltage flag has no effect during soft-start, so `sw_en` stays 1 for the whole ramp.
- R9: In the cycle after an edge that samples `ov_flag`=1 while switching continues, `force_low` is 1. It returns to 0 the cycle after `ov_flag` is sampled 0, and it is 1 only while `sw_en` is 1.
- R10: `shdn_n`=0 clears `sw_en` from the next cycle. Release starts a new soft-start. Shutdown clears the over-current count, so three events before it and three after it do not latch.
- R11: A latched fault is released by `shdn_n`=0 or by `supply_ok`=0, and the next cycle shows `fault_latched`=0.
- R12: When over-current and under-voltage are sampled in the same regulation cycle, the over-current response wins: the off time is one cycle, not the hiccup delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good comparator output, hysteresis applied upstream |
| shdn_n | input | 1 | Active-low shutdown request |
| oc_flag | input | 1 | Over-current comparator, valid during low-side conduction |
| uv_flag | input | 1 | Feedback under-voltage comparator |
| ov_flag | input | 1 | Feedback over-voltage comparator |
| ref_code | output | REF_W | Reference code to the error amplifier DAC |
| sw_en | output | 1 | Switching enable for the gate drivers |
| fault_latched | output | 1 | Over-current latch-off indication |
| force_low | output | 1 | Request to hold the low-side switch on |

## Verification
The properties assume that every flag is already synchronous to `clk` and free of glitches. They also assume the over-current flag is meaningful whenever it is sampled high. The block does no filtering of its own, so any single sampled pulse counts as one event.

The stimulus changes inputs only just after a rising edge and holds over-current and under-voltage pulses for exactly one sample where an event count matters. This keeps each intended event distinct. Test parameters are scaled down (a step of 2 cycles, a target of 12 and a 20-cycle hiccup) so the ramp and the delays can be swept cycle by cycle.

// File: rtl/ssfault_pkg.sv
package ssfault_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SOFT   = 3'd1,
      ST_RUN    = 3'd2,
      ST_OCOFF  = 3'd3,
      ST_UVWAIT = 3'd4,
      ST_LATCH  = 3'd5
   } seq_state_e;

   function automatic logic is_switching(seq_state_e s);
      return (s == ST_SOFT) || (s == ST_RUN);
   endfunction

endpackage

// File: rtl/ssf_ramp.sv
module ssf_ramp #(
   parameter int CODE_W   = 10,
   parameter int TARGET   = 409,
   parameter int STEP_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   output logic [CODE_W-1:0] code,
   output logic              at_target
);

   localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET);

   logic step;

   generate
      if (STEP_CYC == 1) begin : g_every_cycle
         assign step = 1'b1;
      end else begin : g_prescale
         localparam int PW = $clog2(STEP_CYC);
         localparam logic [PW-1:0] PMAX = PW'(STEP_CYC - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pre <= '0;
            else if (clear)      pre <= '0;
            else if (pre == PMAX) pre <= '0;
            else                 pre <= pre + 1'b1;
         end
         assign step = (pre == PMAX);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  code <= '0;
      else if (clear)              code <= '0;
      else if (step && code != TGT) code <= code + 1'b1;
   end

   assign at_target = (code == TGT);

endmodule

// File: rtl/ssf_hiccup.sv
module ssf_hiccup #(
   parameter int DELAY_CYC = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic expired
);

   localparam int TW = $clog2(DELAY_CYC + 1);
   localparam logic [TW-1:0] LAST = TW'(DELAY_CYC - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!active)  cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assign expired = active && (cnt == LAST);

endmodule

// File: rtl/ssf_occnt.sv
module ssf_occnt #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count <= '0;
      else if (clear)                count <= '0;
      else if (bump && count != SAT) count <= count + 1'b1;
   end

endmodule

// File: rtl/ssfault_seq.sv
module ssfault_seq
   import ssfault_pkg::*;
#(
   parameter int REF_W      = 10,
   parameter int REF_CODE   = 409,
   parameter int FULL_CODE  = 1023,
   parameter int STEP_CYC   = 8,
   parameter int HICCUP_CYC = 4096,
   parameter int OC_LIMIT   = 4,
   parameter int OCNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok,
   input  logic             shdn_n,
   input  logic             oc_flag,
   input  logic             uv_flag,
   input  logic             ov_flag,
   output logic [REF_W-1:0] ref_code,
   output logic             sw_en,
   output logic             fault_latched,
   output logic             force_low
);

   localparam logic [OCNT_W-1:0] OC_LAST = OCNT_W'(OC_LIMIT - 1);
   localparam logic [REF_W-1:0]  REF_VAL = REF_W'(REF_CODE);

   generate
      if (REF_CODE < 1 || REF_CODE > FULL_CODE) begin : g_bad_ref
         $error("REF_CODE must lie in 1..FULL_CODE");
      end
      if (FULL_CODE >= (1 << REF_W)) begin : g_bad_full
         $error("FULL_CODE does not fit in REF_W bits");
      end
      if (STEP_CYC < 1) begin : g_bad_step
         $error("STEP_CYC must be at least 1");
      end
      if (HICCUP_CYC < 2) begin : g_bad_hic
         $error("HICCUP_CYC must be at least 2");
      end
      if (OC_LIMIT < 1 || OC_LIMIT >= (1 << OCNT_W)) begin : g_bad_oc
         $error("OC_LIMIT must lie below the counter saturation value");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   logic [REF_W-1:0]  ramp_code;
   logic              ramp_done;
   logic              hic_done;
   logic [OCNT_W-1:0] oc_count;
   logic              oc_bump;
   logic              oc_clear;
   logic              force_q;

   ssf_ramp #(
      .CODE_W   (REF_W),
      .TARGET   (REF_CODE),
      .STEP_CYC (STEP_CYC)
   ) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q != ST_SOFT),
      .code      (ramp_code),
      .at_target (ramp_done)
   );

   ssf_hiccup #(
      .DELAY_CYC (HICCUP_CYC)
   ) u_hiccup (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (state_q == ST_UVWAIT),
      .expired (hic_done)
   );

   assign oc_clear = !supply_ok || !shdn_n;

   ssf_occnt #(
      .CNT_W (OCNT_W)
   ) u_occnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (oc_clear),
      .bump  (oc_bump),
      .count (oc_count)
   );

   always_comb begin
      state_d = state_q;
      oc_bump = 1'b0;
      if (!supply_ok || !shdn_n) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:   state_d = ST_SOFT;
            ST_SOFT: begin
               if (oc_flag) begin
                  oc_bump = 1'b1;
                  state_d = (oc_count >= OC_LAST) ? ST_LATCH : ST_OCOFF;
               end else if (ramp_done) begin
                  state_d = ST_RUN;
               end
            end
            ST_RUN: begin
               if (oc_flag) begin
                  oc_bump = 1'b1;
                  state_d = (oc_count >= OC_LAST) ? ST_LATCH : ST_OCOFF;
               end else if (uv_flag) begin
                  state_d = ST_UVWAIT;
               end
            end
            ST_OCOFF:  state_d = ST_SOFT;
            ST_UVWAIT: if (hic_done) state_d = ST_SOFT;
            ST_LATCH:  state_d = ST_LATCH;
            default:   state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         force_q <= 1'b0;
      end else begin
         state_q <= state_d;
         force_q <= ov_flag && is_switching(state_d);
      end
   end

   always_comb begin
      unique case (state_q)
         ST_RUN:  ref_code = REF_VAL;
         ST_SOFT: ref_code = ramp_code;
         default: ref_code = '0;
      endcase
   end

   assign sw_en         = is_switching(state_q);
   assign fault_latched = (state_q == ST_LATCH);
   assign force_low     = force_q;

endmodule

// File: rtl/ssfault_seq_chk.sv
module ssfault_seq_chk #(
   parameter int REF_W    = 10,
   parameter int REF_CODE = 409
) (
   input logic             clk,
   input logic             rst_n,
   input logic             supply_ok,
   input logic             shdn_n,
   input logic             oc_flag,
   input logic [REF_W-1:0] ref_code,
   input logic             sw_en,
   input logic             fault_latched,
   input logic             force_low
);

   p_supply_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!sw_en && !fault_latched && !force_low && ref_code == '0));

   p_ref_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, ref_code} <= (REF_W+1)'(REF_CODE));

   p_ref_slope_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && $past(sw_en)) |->
         (ref_code >= $past(ref_code)) &&
         ({1'b0, ref_code} <= {1'b0, $past(ref_code)} + 1'b1));

   p_oc_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && oc_flag) |=> !sw_en);

   p_latch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> (!sw_en && !force_low));

   p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched && supply_ok && shdn_n) |=> fault_latched);

   p_force_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      force_low |-> sw_en);

   p_shdn_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |=> (!sw_en && !fault_latched));

endmodule

bind ssfault_seq ssfault_seq_chk #(
   .REF_W    (REF_W),
   .REF_CODE (REF_CODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .supply_ok     (supply_ok),
   .shdn_n        (shdn_n),
   .oc_flag       (oc_flag),
   .ref_code      (ref_code),
   .sw_en         (sw_en),
   .fault_latched (fault_latched),
   .force_low     (force_low)
);

// File: tb/ssfault_seq_tb.sv
module ssfault_seq_tb;

   localparam int RW   = 10;
   localparam int STEP = 2;
   localparam int REFC = 12;
   localparam int HIC  = 20;
   localparam int OCL  = 4;

   logic clk = 1'b0;
   logic rst_n, supply_ok, shdn_n, oc_flag, uv_flag, ov_flag;
   logic [RW-1:0] ref_code;
   logic sw_en, fault_latched, force_low;

   int n_run  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ssfault_seq #(
      .REF_W      (RW),
      .REF_CODE   (REFC),
      .FULL_CODE  (1023),
      .STEP_CYC   (STEP),
      .HICCUP_CYC (HIC),
      .OC_LIMIT   (OCL),
      .OCNT_W     (3)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .supply_ok     (supply_ok),
      .shdn_n        (shdn_n),
      .oc_flag       (oc_flag),
      .uv_flag       (uv_flag),
      .ov_flag       (ov_flag),
      .ref_code      (ref_code),
      .sw_en         (sw_en),
      .fault_latched (fault_latched),
      .force_low     (force_low)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ramp_to_run();
      for (int i = 1; i <= REFC*STEP + 1; i++) tick();
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; supply_ok = 1'b0; shdn_n = 1'b1;
      oc_flag = 1'b0; uv_flag = 1'b0; ov_flag = 1'b0;
      tick(); tick(); tick();
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tick();
         chk("R1 sw_en", int'(sw_en), 0);
         chk("R1 ref", int'(ref_code), 0);
         chk("R1 fault", int'(fault_latched), 0);
         chk("R1 force", int'(force_low), 0);
      end

      // R2 start-up, then R3 ramp sweep cycle by cycle
      supply_ok = 1'b1;
      tick();
      chk("R2 sw_en", int'(sw_en), 1);
      chk("R2 ref", int'(ref_code), 0);
      for (int k = 1; k <= REFC*STEP; k++) begin
         tick();
         chk("R3 ramp", int'(ref_code), k / STEP);
         chk("R3 sw_en", int'(sw_en), 1);
      end
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R4 hold", int'(ref_code), REFC);
         chk("R4 sw_en", int'(sw_en), 1);
      end

      // R9 over-voltage
      ov_flag = 1'b1;
      tick();
      chk("R9 force on", int'(force_low), 1);
      chk("R9 ref", int'(ref_code), REFC);
      tick();
      chk("R9 force held", int'(force_low), 1);
      ov_flag = 1'b0;
      tick();
      chk("R9 force off", int'(force_low), 0);

      // R7 single under-voltage hiccup
      uv_flag = 1'b1;
      tick();
      chk("R7 off", int'(sw_en), 0);
      uv_flag = 1'b0;
      for (int i = 2; i <= HIC; i++) begin
         tick();
         chk("R7 wait", int'(sw_en), 0);
      end
      tick();
      chk("R7 restart", int'(sw_en), 1);
      chk("R7 restart ref", int'(ref_code), 0);

      // R8 masking during ramp, R7 repeated hiccup without latching
      uv_flag = 1'b1;
      for (int p = 0; p < 2; p++) begin
         for (int i = 1; i <= REFC*STEP + 1; i++) begin
            tick();
            chk("R8 masked", int'(sw_en), 1);
         end
         tick();
         chk("R7 repeat off", int'(sw_en), 0);
         for (int i = 2; i <= HIC; i++) begin
            tick();
            chk("R7 repeat wait", int'(sw_en), 0);
            chk("R7 no latch", int'(fault_latched), 0);
         end
         tick();
         chk("R7 repeat restart", int'(sw_en), 1);
         chk("R7 repeat ref", int'(ref_code), 0);
      end
      uv_flag = 1'b0;

      // R5 over-current in regulation (count 1)
      ramp_to_run();
      chk("R4 reached", int'(ref_code), REFC);
      oc_flag = 1'b1;
      tick();
      chk("R5 off", int'(sw_en), 0);
      chk("R5 ref", int'(ref_code), 0);
      oc_flag = 1'b0;
      tick();
      chk("R5 restart", int'(sw_en), 1);
      chk("R5 restart ref", int'(ref_code), 0);

      // R5 over-current during the ramp (count 2)
      tick(); tick(); tick();
      chk("R3 mid ramp", int'(ref_code), 3 / STEP);
      oc_flag = 1'b1;
      tick();
      chk("R5 ramp off", int'(sw_en), 0);
      oc_flag = 1'b0;
      tick();
      chk("R5 ramp restart", int'(ref_code), 0);
      chk("R5 ramp restart en", int'(sw_en), 1);

      // R12 simultaneous faults (count 3)
      ramp_to_run();
      oc_flag = 1'b1; uv_flag = 1'b1;
      tick();
      chk("R12 off", int'(sw_en), 0);
      oc_flag = 1'b0; uv_flag = 1'b0;
      tick();
      chk("R12 short off", int'(sw_en), 1);
      chk("R12 no latch", int'(fault_latched), 0);

      // R10 shutdown clears the count
      shdn_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R10 shdn off", int'(sw_en), 0);
      end
      shdn_n = 1'b1;
      tick();
      chk("R10 release", int'(sw_en), 1);
      chk("R10 release ref", int'(ref_code), 0);
      for (int j = 0; j < OCL - 1; j++) begin
         oc_flag = 1'b1;
         tick();
         chk("R10 oc off", int'(sw_en), 0);
         oc_flag = 1'b0;
         tick();
         chk("R10 oc restart", int'(sw_en), 1);
      end
      chk("R10 count cleared", int'(fault_latched), 0);

      // R6 fourth event latches
      oc_flag = 1'b1;
      tick();
      chk("R6 latch", int'(fault_latched), 1);
      chk("R6 off", int'(sw_en), 0);
      for (int i = 0; i < 10; i++) begin
         oc_flag = i[0];
         uv_flag = i[1];
         ov_flag = 1'b1;
         tick();
         chk("R6 held", int'(fault_latched), 1);
         chk("R6 held off", int'(sw_en), 0);
         chk("R6 no force", int'(force_low), 0);
         chk("R6 ref", int'(ref_code), 0);
      end
      oc_flag = 1'b0; uv_flag = 1'b0; ov_flag = 1'b0;

      // R11 release by shutdown
      shdn_n = 1'b0;
      tick();
      chk("R11 shdn clear", int'(fault_latched), 0);
      shdn_n = 1'b1;
      tick();
      chk("R11 shdn restart", int'(sw_en), 1);

      // R11 release by supply loss
      for (int j = 0; j < OCL - 1; j++) begin
         oc_flag = 1'b1; tick();
         oc_flag = 1'b0; tick();
      end
      oc_flag = 1'b1;
      tick();
      oc_flag = 1'b0;
      chk("R6 relatch", int'(fault_latched), 1);
      tick();
      chk("R6 relatch hold", int'(fault_latched), 1);
      supply_ok = 1'b0;
      tick();
      chk("R11 supply clear", int'(fault_latched), 0);
      chk("R1 supply off", int'(sw_en), 0);
      supply_ok = 1'b1;
      tick();
      chk("R11 supply restart", int'(sw_en), 1);
      chk("R11 supply ref", int'(ref_code), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule